// File: doc/BRIEF.md
# DMA Start-Vector Matcher with Chaining

This block sits between an interrupt controller and a set of DMA channels. It holds, for each of four channels, a programmed 6-bit start vector and a transfer counter. The interrupt controller presents its pending request as a 6-bit vector. If an assigned channel holds the same vector, the request goes to that channel as a trigger pulse, and the source's pending flag is cleared through an acknowledge output. If no channel holds the vector, the request is passed on to the CPU unchanged.

Each accepted trigger lowers the channel's counter by one. The trigger that takes the counter from one to zero also does two things: it raises the channel's transfer-end interrupt, and it erases the channel's start vector, so the channel drops its binding to the source. When several channels hold the same vector, the lowest-numbered assigned channel always wins. Once its binding erases itself, the next higher channel with that vector takes over, which chains transfers across channels. Software can also write a vector to a clear register, which emits a one-cycle request to clear the pending flag with that vector. The data movement itself is done elsewhere.

Writes use one port. The address is {sel[1:0], ch[1:0]}, where sel 0 selects a channel's vector register, sel 1 selects a channel's counter, and sel 2 selects the clear register. The vector is taken from data bits [5:0]. Every output is registered and appears one clock after its cause.

Top module: `dma_vec_router`

## Requirements
- R1: A request whose vector equals an assigned channel's vector produces a one-cycle pulse on exactly that channel's bit of ch_trig in the cycle after the request. A channel is assigned when both its vector and its counter are non-zero.
- R2: A request that is accepted by a channel is not forwarded to cpu_irq_valid. In the same cycle as the trigger, flag_clr_valid pulses with flag_clr_vec equal to the request vector.
- R3: A request that matches no assigned channel produces cpu_irq_valid with cpu_irq_vec equal to the request vector one cycle later, and no trigger.
- R4: Each trigger lowers that channel's counter by exactly one, so a counter programmed to N accepts exactly N triggers.
- R5: The trigger that takes a counter from 1 to 0 also pulses that channel's bit of ch_end in the same cycle and sets the channel's vector to 0. Further requests with the old vector then no longer reach that channel.
- R6: When several assigned channels hold the same vector, the lowest-numbered one is triggered. After it exhausts, the next higher channel with that vector receives the following requests.
- R7: A request with vector 0 never triggers a channel. It is forwarded to the CPU.
- R8: A channel whose counter is written with 0 never triggers and never raises ch_end, whatever its vector.
- R9: A write with sel 2 pulses sw_clr_valid for one cycle, with sw_clr_vec equal to data bits [5:0], and leaves all channels unchanged.
- R10: A software write to a channel register in the same cycle as a trigger of that channel takes precedence over the hardware update of that register. Reprogramming the vector after exhaustion restores the channel's priority.
- R11: After reset, every output is 0 and every channel is unassigned, so every request goes to the CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address {sel[1:0], ch[1:0]} |
| wr_data | input | 16 | Write data: counter value, or vector in bits [5:0] |
| req_valid | input | 1 | A pending interrupt request is presented |
| req_vec | input | 6 | Vector of the presented request |
| ch_trig | output | 4 | Per-channel DMA trigger pulse |
| ch_end | output | 4 | Per-channel transfer-end interrupt pulse |
| cpu_irq_valid | output | 1 | Request forwarded to the CPU |
| cpu_irq_vec | output | 6 | Vector of the forwarded request (0 when not valid) |
| flag_clr_valid | output | 1 | Clear the pending flag of an accepted request |
| flag_clr_vec | output | 6 | Vector whose flag is cleared (0 when not valid) |
| sw_clr_valid | output | 1 | Software clear-register pulse |
| sw_clr_vec | output | 6 | Vector written to the clear register |

## Verification
The assertions on the counter step and on vector erasure assume that a hardware update is checked only in cycles without a software write to the same register. For that reason they are qualified by the previous cycle's write strobes. The bench presents at most one request per cycle, each as a single-cycle pulse followed by an idle cycle, and it keeps write data within the declared widths. Only the precedence test deliberately overlaps a write with a trigger of the same channel, and the assertions are written so that the overlap is excluded from the precedence-sensitive checks.

// File: rtl/dvm_pkg.sv
package dvm_pkg;
  typedef enum logic [1:0] {
    SEL_VEC = 2'd0,
    SEL_CNT = 2'd1,
    SEL_CLR = 2'd2,
    SEL_RSV = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dvm_chan.sv
module dvm_chan #(
  parameter int VEC_W = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             grant,
  output logic             hit,
  output logic             trig_q,
  output logic             end_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [VEC_W-1:0] vec_q, vec_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  assign last = (cnt_q == ONE);
  assign hit  = req_valid && (vec_q != '0) && (cnt_q != '0) && (vec_q == req_vec);

  always_comb begin
    vec_d = vec_q;
    cnt_d = cnt_q;
    if (grant) begin
      cnt_d = cnt_q - ONE;
      if (last) vec_d = '0;
    end
    if (vec_we) vec_d = wdata[VEC_W-1:0];
    if (cnt_we) cnt_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      cnt_q  <= '0;
      trig_q <= 1'b0;
      end_q  <= 1'b0;
    end else begin
      if (grant || vec_we) vec_q <= vec_d;
      if (grant || cnt_we) cnt_q <= cnt_d;
      trig_q <= grant;
      end_q  <= grant && last;
    end
  end

  assert_end_with_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> trig_q);
  assert_end_erases_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_q && !$past(vec_we)) |-> (vec_q == '0));
  assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q && !$past(cnt_we)) |-> (cnt_q == $past(cnt_q) - ONE));
  assert_trig_assigned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |-> ($past(vec_q) != '0));
  assert_end_needs_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    end_q |-> ($past(cnt_q) == ONE));
endmodule

// File: rtl/dvm_arb.sv
module dvm_arb #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] grant
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_pri
    if (i == 0) begin : g_first
      assign grant[i] = hit[i];
    end else begin : g_rest
      assign grant[i] = hit[i] && !(|hit[i-1:0]);
    end
  end
endmodule

// File: rtl/dma_vec_router.sv
module dma_vec_router #(
  parameter int NUM_CH = 4,
  parameter int VEC_W  = 6,
  parameter int CNT_W  = 16,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              req_valid,
  input  logic [VEC_W-1:0]  req_vec,
  output logic [NUM_CH-1:0] ch_trig,
  output logic [NUM_CH-1:0] ch_end,
  output logic              cpu_irq_valid,
  output logic [VEC_W-1:0]  cpu_irq_vec,
  output logic              flag_clr_valid,
  output logic [VEC_W-1:0]  flag_clr_vec,
  output logic              sw_clr_valid,
  output logic [VEC_W-1:0]  sw_clr_vec
);
  import dvm_pkg::*;

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  reg_sel_e         sel;
  logic [CH_W-1:0]  wch;
  logic [NUM_CH-1:0] hit, grant;
  logic             miss, swc;

  assign sel  = reg_sel_e'(wr_addr[ADDR_W-1 -: 2]);
  assign wch  = wr_addr[CH_W-1:0];
  assign miss = req_valid && (grant == '0);
  assign swc  = wr_en && (sel == SEL_CLR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic vwe, cwe;
    assign vwe = wr_en && (sel == SEL_VEC) && (wch == CH_W'(c));
    assign cwe = wr_en && (sel == SEL_CNT) && (wch == CH_W'(c));
    dvm_chan #(.VEC_W(VEC_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_ni), .vec_we(vwe), .cnt_we(cwe),
      .wdata(wr_data), .req_valid(req_valid), .req_vec(req_vec),
      .grant(grant[c]), .hit(hit[c]), .trig_q(ch_trig[c]), .end_q(ch_end[c])
    );
  end

  dvm_arb #(.NUM_CH(NUM_CH)) u_arb (.hit(hit), .grant(grant));

  logic             cpu_v_d, ack_v_d, sw_v_d;
  logic [VEC_W-1:0] cpu_vec_d, ack_vec_d, sw_vec_d;

  always_comb begin
    cpu_v_d   = miss;
    cpu_vec_d = miss ? req_vec : '0;
    ack_v_d   = |grant;
    ack_vec_d = (|grant) ? req_vec : '0;
    sw_v_d    = swc;
    sw_vec_d  = swc ? wr_data[VEC_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_irq_valid  <= 1'b0;
      cpu_irq_vec    <= '0;
      flag_clr_valid <= 1'b0;
      flag_clr_vec   <= '0;
      sw_clr_valid   <= 1'b0;
      sw_clr_vec     <= '0;
    end else begin
      cpu_irq_valid  <= cpu_v_d;
      cpu_irq_vec    <= cpu_vec_d;
      flag_clr_valid <= ack_v_d;
      flag_clr_vec   <= ack_vec_d;
      sw_clr_valid   <= sw_v_d;
      sw_clr_vec     <= sw_vec_d;
    end
  end

  assert_one_trig_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(ch_trig));
  assert_cpu_excl_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_irq_valid |-> (ch_trig == '0));
  assert_ack_pairs_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    flag_clr_valid |-> $onehot(ch_trig));
  assert_cpu_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    cpu_irq_valid |-> $past(req_valid));
endmodule

// File: tb/tb_dma_vec_router.sv
`timescale 1ns/1ps
module tb_dma_vec_router;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        req_valid;
  logic [5:0]  req_vec;
  logic [3:0]  ch_trig, ch_end;
  logic        cpu_irq_valid, flag_clr_valid, sw_clr_valid;
  logic [5:0]  cpu_irq_vec, flag_clr_vec, sw_clr_vec;

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0]  mvec [4];
  logic [15:0] mcnt [4];

  always #4 clk = ~clk;

  dma_vec_router dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_vec(req_vec), .ch_trig(ch_trig), .ch_end(ch_end),
    .cpu_irq_valid(cpu_irq_valid), .cpu_irq_vec(cpu_irq_vec),
    .flag_clr_valid(flag_clr_valid), .flag_clr_vec(flag_clr_vec),
    .sw_clr_valid(sw_clr_valid), .sw_clr_vec(sw_clr_vec)
  );

  function automatic logic [28:0] outs();
    return {ch_trig, ch_end, cpu_irq_valid, cpu_irq_vec,
            flag_clr_valid, flag_clr_vec, sw_clr_valid, sw_clr_vec};
  endfunction

  task automatic cmp(input logic [28:0] exp, input string tag);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, outs(), exp);
    end
  endtask

  // one cycle: optional request and optional write, checked one clock later
  task automatic step(input bit rq, input logic [5:0] v, input bit wr,
                      input logic [3:0] a, input logic [15:0] d, input string tag);
    int g = -1;
    bit e = 0;
    logic [28:0] exp;
    if (rq)
      for (int c = 3; c >= 0; c--)
        if (mvec[c] != 0 && mcnt[c] != 0 && mvec[c] == v) g = c;
    if (g >= 0) begin
      e = (mcnt[g] == 1);
      mcnt[g] = mcnt[g] - 1;
      if (e) mvec[g] = 0;
    end
    exp = '0;
    if (g >= 0) begin
      exp[28:25] = 4'(1 << g);
      if (e) exp[24:21] = 4'(1 << g);
      exp[13] = 1'b1;
      exp[12:7] = v;
    end else if (rq) begin
      exp[20] = 1'b1;
      exp[19:14] = v;
    end
    if (wr && a[3:2] == 2'd2) begin
      exp[6] = 1'b1;
      exp[5:0] = d[5:0];
    end
    if (wr && a[3:2] == 2'd0) mvec[a[1:0]] = d[5:0];
    if (wr && a[3:2] == 2'd1) mcnt[a[1:0]] = d;
    @(negedge clk);
    req_valid = rq; req_vec = v; wr_en = wr; wr_addr = a; wr_data = d;
    @(negedge clk);
    cmp(exp, tag);
    req_valid = 0; wr_en = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d, input string tag);
    step(0, 6'd0, 1, a, d, tag);
  endtask

  task automatic rq(input logic [5:0] v, input string tag);
    step(1, v, 0, 4'd0, 16'd0, tag);
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin mvec[c] = 0; mcnt[c] = 0; end
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; req_valid = 0; req_vec = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp('0, "R11 reset outputs");
    rq(6'h0A, "R11 unassigned after reset");

    // R1 R3 R7: sweep of all vectors against four distinct bindings
    wr(4'h0, 16'h000A, "R1 setup"); wr(4'h4, 16'd200, "R1 setup");
    wr(4'h1, 16'h0015, "R1 setup"); wr(4'h5, 16'd200, "R1 setup");
    wr(4'h2, 16'h002A, "R1 setup"); wr(4'h6, 16'd200, "R1 setup");
    wr(4'h3, 16'h003F, "R1 setup"); wr(4'h7, 16'd200, "R1 setup");
    for (int v = 0; v < 64; v++)
      rq(6'(v), (v == 0) ? "R7 zero vector" :
               (v == 10 || v == 21 || v == 42 || v == 63) ? "R1 R2 match" : "R3 miss");

    // R8: zero counter makes the channel inert
    wr(4'h6, 16'd0, "R8 zero count");
    rq(6'h2A, "R8 no trigger no end");

    // R9: clear register
    wr(4'h8, 16'h000A, "R9 clear register");
    wr(4'h8, 16'hFF3C, "R9 clear register high bits");
    rq(6'h0A, "R9 channels unchanged");

    // R4 R5 R6: chaining, ch1 and ch3 share 0x0A, ch0 moved away
    wr(4'h0, 16'h0001, "R6 setup"); wr(4'h4, 16'd0, "R6 setup");
    wr(4'h1, 16'h000A, "R6 setup"); wr(4'h5, 16'd2, "R6 setup");
    wr(4'h3, 16'h000A, "R6 setup"); wr(4'h7, 16'd3, "R6 setup");
    rq(6'h0A, "R6 lowest wins");
    rq(6'h0A, "R5 end on ch1");
    rq(6'h0A, "R6 chain to ch3");
    rq(6'h0A, "R4 decrement ch3");
    rq(6'h0A, "R5 end on ch3");
    rq(6'h0A, "R5 vector erased to CPU");

    // R10: counter write during final trigger wins; vector still erased
    wr(4'h1, 16'h0011, "R10 setup"); wr(4'h5, 16'd1, "R10 setup");
    wr(4'h3, 16'h0011, "R10 setup"); wr(4'h7, 16'd1, "R10 setup");
    step(1, 6'h11, 1, 4'h5, 16'd2, "R10 write with last trigger");
    rq(6'h11, "R10 chain after erase");
    wr(4'h1, 16'h0011, "R10 reprogram vector");
    rq(6'h11, "R10 priority restored");
    rq(6'h11, "R10 counter kept written value");
    rq(6'h11, "R10 all exhausted");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule